// File: doc/BRIEF.md
# Busy-Gated Slave Dual-Port Memory

This block is a two-port synchronous memory slice, 1024 words of 8 bits, meant to be stacked beside a master slice so that several slices together present a wider word to two independent requesters. It has no arbiter of its own. Each port instead receives an active-low busy input from the master's arbiter and uses it to decide whether a write may land.

A write request on a port (chip select low, write-not-read low) is captured and then held for a settle window of `SETTLE_CYC` clock cycles. The window stands in for the master's worst-case arbitration time. At the end of the window the write is committed only if the port's busy input is high and the request is still asserted. Otherwise it is discarded and a one-cycle `*_wr_dropped` pulse is raised. Reads are registered and return one cycle after they are sampled. Read data sampled while busy is low is marked as suspect.

Each port runs a small write sequencer with three states. WR_IDLE moves to WR_SETTLE when a request is seen (transition *accept*). WR_SETTLE counts the window and, on its last cycle, moves to WR_HOLD (transition *decide*, which either commits or drops). WR_HOLD returns to WR_IDLE once the request is withdrawn (transition *release*). A write held low for a long time therefore writes exactly once.

Top module: `slave_dpram`

## Requirements
- R1: Either port can write any of the 1024 locations (10-bit address, 8-bit data), and the written value is read back identically from either port.
- R2: A read is sampled at a rising edge when chip select is low, write-not-read is high and output enable is low. In the following cycle, `*_rvalid` is 1 and `*_rdata` holds the word stored at that address.
- R3: While chip select is high, a port neither reads nor writes, whatever its other inputs. `*_rvalid` stays 0, `*_wr_dropped` stays 0, and memory is left unchanged.
- R4: A write whose request is accepted at edge E0 changes memory at edge E0+`SETTLE_CYC` (default 2) and not earlier. A read of that address sampled before that edge returns the previous word.
- R5: If the port's busy input is 0 at the decision edge, the pending write is discarded and memory keeps its previous word.
- R6: A discarded write raises `*_wr_dropped` to 1 for exactly the one cycle following the decision edge. A committed write leaves it at 0.
- R7: A write request withdrawn (chip select or write-not-read driven high) before the decision edge is discarded, as in R5 and R6.
- R8: A request held asserted after its decision writes only once. Changing the write data while it is still held does not alter memory until the request is released and a new one accepted.
- R9: `*_rdata_suspect` is 1, alongside `*_rvalid`, for a read sampled while that port's busy input is 0, and is 0 for a read sampled with busy at 1.
- R10: After reset, `*_rvalid`, `*_rdata`, `*_rdata_suspect` and `*_wr_dropped` are all 0.
- R11: Busy on one port has no effect on the other port: a write on a port whose own busy is 1 commits even while the other port's busy is 0.
- R12: While output enable is high, a sampled read gives `*_rvalid` = 0 and `*_rdata` = 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_we_n | input | 1 | Port A write-not-read: 0 write, 1 read |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | 10 | Port A word address |
| a_wdata | input | 8 | Port A write data |
| a_busy_n | input | 1 | Port A busy from master arbiter, active low |
| a_rdata | output | 8 | Port A read data, 0 when not valid |
| a_rvalid | output | 1 | Port A read data valid |
| a_rdata_suspect | output | 1 | Port A read was sampled with busy low |
| a_wr_dropped | output | 1 | Port A pending write discarded (one cycle) |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_we_n | input | 1 | Port B write-not-read: 0 write, 1 read |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | 10 | Port B word address |
| b_wdata | input | 8 | Port B write data |
| b_busy_n | input | 1 | Port B busy from master arbiter, active low |
| b_rdata | output | 8 | Port B read data, 0 when not valid |
| b_rvalid | output | 1 | Port B read data valid |
| b_rdata_suspect | output | 1 | Port B read was sampled with busy low |
| b_wr_dropped | output | 1 | Port B pending write discarded (one cycle) |

## Verification
Read results appear one cycle after the sampling edge. The read driver pushes the expected word and suspect flag when it presents the address, and a monitor pops and compares at the falling edge after that sampling edge. A write's outcome is due at edge E0+`SETTLE_CYC`. The drop pulse is therefore checked at the falling edge just after that decision edge and again one cycle later, when it must be gone. Memory effects are checked by later reads through either port, and one read is deliberately timed inside the settle window to show that the old word is still in place.

// File: rtl/slv_pkg.sv
package slv_pkg;

    // Write sequencer states, one sequencer per port
    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_SETTLE = 2'd1,
        WR_HOLD   = 2'd2
    } wr_state_t;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/slv_port_ctrl.sv
module slv_port_ctrl
    import slv_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy_n,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              rd_valid,
    output logic              rd_suspect,
    output logic              wr_dropped
);

    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYC - 1);

    wr_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] waddr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              drop_q;
    logic              rvalid_q;
    logic              rsusp_q;

    logic wr_req;
    logic rd_req;
    logic win_last;
    logic decide;
    logic commit;
    logic drop_now;

    assign wr_req   = !cs_n && !we_n;
    assign rd_req   = !cs_n && we_n;
    assign win_last = (cnt_q == LAST_CNT);

    // Next-state and window counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WR_IDLE: begin
                cnt_d = '0;
                if (wr_req) begin
                    state_d = WR_SETTLE;          // accept
                end
            end
            WR_SETTLE: begin
                if (win_last) begin
                    state_d = WR_HOLD;            // decide
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            WR_HOLD: begin
                if (!wr_req) begin
                    state_d = WR_IDLE;            // release
                end
            end
            default: begin
                state_d = WR_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= WR_IDLE;
            cnt_q    <= '0;
            waddr_q  <= '0;
            wdata_q  <= '0;
            drop_q   <= 1'b0;
            rvalid_q <= 1'b0;
            rsusp_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            if (state_q == WR_IDLE && wr_req) begin
                waddr_q <= addr;
                wdata_q <= wdata;
            end
            drop_q   <= drop_now;
            rvalid_q <= rd_req && !oe_n;
            rsusp_q  <= rd_req && !oe_n && !busy_n;
        end
    end

    // Outputs
    always_comb begin
        decide     = (state_q == WR_SETTLE) && win_last;
        commit     = decide && wr_req && busy_n;
        drop_now   = decide && !commit;
        mem_we     = commit;
        mem_waddr  = waddr_q;
        mem_wdata  = wdata_q;
        mem_re     = rd_req;
        mem_raddr  = addr;
        rd_valid   = rvalid_q;
        rd_suspect = rsusp_q;
        wr_dropped = drop_q;
    end

    // Independent age counter: edges since the request was accepted
    logic [CNT_W:0] chk_age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_age_q <= '0;
        end else if (state_q == WR_IDLE && wr_req) begin
            chk_age_q <= (CNT_W+1)'(1);
        end else if (state_q == WR_SETTLE) begin
            chk_age_q <= chk_age_q + 1'b1;
        end else begin
            chk_age_q <= '0;
        end
    end

    assert_commit_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (chk_age_q == (CNT_W+1)'(SETTLE_CYC)));

    assert_drop_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dropped |=> !wr_dropped);

    assert_drop_not_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !wr_dropped);

    assert_single_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_suspect_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_suspect |-> rd_valid);

endmodule

// File: rtl/slv_mem_core.sv
module slv_mem_core
    import slv_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_PORTS-1:0]                we,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    waddr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]    wdata,
    input  logic [NUM_PORTS-1:0]                re,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    raddr,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]    rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Writes from both ports; same-address collision is undefined
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (we[p]) begin
                store[waddr[p]] <= wdata[p];
            end
        end
    end

    // Registered reads, old data on a same-edge write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (re[p]) begin
                    rdata[p] <= store[raddr[p]];
                end
            end
        end
    end

endmodule

// File: rtl/slave_dpram.sv
module slave_dpram
    import slv_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_cs_n,
    input  logic              a_we_n,
    input  logic              a_oe_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_busy_n,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    output logic              a_rdata_suspect,
    output logic              a_wr_dropped,
    input  logic              b_cs_n,
    input  logic              b_we_n,
    input  logic              b_oe_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_busy_n,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid,
    output logic              b_rdata_suspect,
    output logic              b_wr_dropped
);

    logic [NUM_PORTS-1:0]             p_cs_n, p_we_n, p_oe_n, p_busy_n;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] p_addr;
    logic [NUM_PORTS-1:0][DATA_W-1:0] p_wdata;

    logic [NUM_PORTS-1:0]             m_we, m_re;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] m_waddr, m_raddr;
    logic [NUM_PORTS-1:0][DATA_W-1:0] m_wdata, m_rdata;
    logic [NUM_PORTS-1:0]             p_rvalid, p_rsusp, p_drop;

    assign p_cs_n   = {b_cs_n,   a_cs_n};
    assign p_we_n   = {b_we_n,   a_we_n};
    assign p_oe_n   = {b_oe_n,   a_oe_n};
    assign p_busy_n = {b_busy_n, a_busy_n};
    assign p_addr   = {b_addr,   a_addr};
    assign p_wdata  = {b_wdata,  a_wdata};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        slv_port_ctrl #(
            .ADDR_W     (ADDR_W),
            .DATA_W     (DATA_W),
            .SETTLE_CYC (SETTLE_CYC)
        ) u_ctrl (
            .clk        (clk),
            .rst_n      (rst_n),
            .cs_n       (p_cs_n[p]),
            .we_n       (p_we_n[p]),
            .oe_n       (p_oe_n[p]),
            .addr       (p_addr[p]),
            .wdata      (p_wdata[p]),
            .busy_n     (p_busy_n[p]),
            .mem_we     (m_we[p]),
            .mem_waddr  (m_waddr[p]),
            .mem_wdata  (m_wdata[p]),
            .mem_re     (m_re[p]),
            .mem_raddr  (m_raddr[p]),
            .rd_valid   (p_rvalid[p]),
            .rd_suspect (p_rsusp[p]),
            .wr_dropped (p_drop[p])
        );

        assert_read_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!p_cs_n[p] && p_we_n[p] && !p_oe_n[p]) |=> p_rvalid[p]);

        assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            p_cs_n[p] |=> !p_rvalid[p]);

        assert_oe_gates_R12: assert property (@(posedge clk) disable iff (!rst_n)
            p_oe_n[p] |=> !p_rvalid[p]);
    end

    slv_mem_core #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (m_we),
        .waddr (m_waddr),
        .wdata (m_wdata),
        .re    (m_re),
        .raddr (m_raddr),
        .rdata (m_rdata)
    );

    always_comb begin
        a_rdata         = p_rvalid[0] ? m_rdata[0] : '0;
        a_rvalid        = p_rvalid[0];
        a_rdata_suspect = p_rsusp[0];
        a_wr_dropped    = p_drop[0];
        b_rdata         = p_rvalid[1] ? m_rdata[1] : '0;
        b_rvalid        = p_rvalid[1];
        b_rdata_suspect = p_rsusp[1];
        b_wr_dropped    = p_drop[1];
    end

endmodule

// File: tb/tb_slave_dpram.sv
`timescale 1ns/1ps
module tb_slave_dpram;

    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       cs_n   [2];
    logic       we_n   [2];
    logic       oe_n   [2];
    logic       busy_n [2];
    logic [9:0] addr   [2];
    logic [7:0] wdata  [2];
    logic [7:0] rdata  [2];
    logic       rvalid [2];
    logic       susp   [2];
    logic       drop   [2];

    slave_dpram #(.ADDR_W(10), .DATA_W(8), .SETTLE_CYC(S)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_cs_n(cs_n[0]), .a_we_n(we_n[0]), .a_oe_n(oe_n[0]), .a_addr(addr[0]),
        .a_wdata(wdata[0]), .a_busy_n(busy_n[0]), .a_rdata(rdata[0]),
        .a_rvalid(rvalid[0]), .a_rdata_suspect(susp[0]), .a_wr_dropped(drop[0]),
        .b_cs_n(cs_n[1]), .b_we_n(we_n[1]), .b_oe_n(oe_n[1]), .b_addr(addr[1]),
        .b_wdata(wdata[1]), .b_busy_n(busy_n[1]), .b_rdata(rdata[1]),
        .b_rvalid(rvalid[1]), .b_rdata_suspect(susp[1]), .b_wr_dropped(drop[1])
    );

    typedef struct {
        logic [7:0] data;
        logic       sus;
        string      tag;
    } exp_t;

    exp_t       q0[$];
    exp_t       q1[$];
    logic [7:0] ref_mem [1024];
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mon_port(input int p);
        exp_t e;
        if (rvalid[p]) begin
            if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
                chk(1'b0, "R2 unexpected rvalid", 1, 0);
            end else begin
                e = (p == 0) ? q0.pop_front() : q1.pop_front();
                chk(rdata[p] == e.data, e.tag, int'(rdata[p]), int'(e.data));
                chk(susp[p] == e.sus, {e.tag, " R9 suspect"}, int'(susp[p]), int'(e.sus));
            end
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            mon_port(0);
            mon_port(1);
        end
    end

    task automatic rd(input int p, input logic [9:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        cs_n[p] = 1'b0; we_n[p] = 1'b1; oe_n[p] = 1'b0; addr[p] = a;
        e.data = ref_mem[a]; e.sus = !busy_n[p]; e.tag = tag;
        if (p == 0) q0.push_back(e); else q1.push_back(e);
        @(posedge clk);
        @(negedge clk);
        cs_n[p] = 1'b1;
    endtask

    task automatic wr(input int p, input logic [9:0] a, input logic [7:0] d,
                      input bit commit, input bit early, input string tag);
        @(negedge clk);
        cs_n[p] = 1'b0; we_n[p] = 1'b0; addr[p] = a; wdata[p] = d;
        if (early) begin
            @(posedge clk);
            @(negedge clk);
            cs_n[p] = 1'b1; we_n[p] = 1'b1;
            repeat (S) @(posedge clk);
            @(negedge clk);
        end else begin
            repeat (S + 1) @(posedge clk);
            @(negedge clk);
        end
        chk(drop[p] == !commit, {tag, " R6 drop pulse"}, int'(drop[p]), int'(!commit));
        cs_n[p] = 1'b1; we_n[p] = 1'b1;
        if (commit) ref_mem[a] = d;
        @(negedge clk);
        chk(drop[p] == 1'b0, {tag, " R6 pulse ends"}, int'(drop[p]), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            cs_n[p] = 1'b1; we_n[p] = 1'b1; oe_n[p] = 1'b1; busy_n[p] = 1'b1;
            addr[p] = '0; wdata[p] = '0;
        end
        repeat (4) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            chk(rvalid[p] == 0 && rdata[p] == 0 && susp[p] == 0 && drop[p] == 0,
                "R10 reset outputs", int'(rdata[p]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 cross-port and same-port access, address corners
        wr(0, 10'd3, 8'hA5, 1, 0, "R1 wrA");
        rd(1, 10'd3, "R1 read B of A write");
        wr(1, 10'd1023, 8'h3C, 1, 0, "R1 wrB");
        rd(0, 10'd1023, "R1 read A top address");
        wr(0, 10'd0, 8'h01, 1, 0, "R1 wrA0");
        rd(0, 10'd0, "R2 same-port read");

        // R4 read inside settle window sees old word
        wr(0, 10'd10, 8'h11, 1, 0, "R4 prep");
        fork
            wr(0, 10'd10, 8'h5A, 1, 0, "R4 wr");
            begin
                @(negedge clk);
                rd(1, 10'd10, "R4 read before commit");
            end
        join
        rd(1, 10'd10, "R4 read after commit");

        // R5 busy low at decision drops write
        busy_n[1] = 1'b0;
        wr(1, 10'd10, 8'hEE, 0, 0, "R5 busy drop");
        busy_n[1] = 1'b1;
        rd(1, 10'd10, "R5 memory unchanged");

        // R11 other port busy does not matter
        busy_n[1] = 1'b0;
        wr(0, 10'd20, 8'h77, 1, 0, "R11 wr");
        busy_n[1] = 1'b1;
        rd(1, 10'd20, "R11 read");

        // R9 read with busy low is suspect
        busy_n[0] = 1'b0;
        rd(0, 10'd20, "R9 suspect read");
        busy_n[0] = 1'b1;

        // R7 early withdrawal drops the write
        wr(0, 10'd10, 8'h99, 0, 1, "R7 early release");
        rd(0, 10'd10, "R7 memory unchanged");

        // R8 held request writes once
        @(negedge clk);
        cs_n[0] = 1'b0; we_n[0] = 1'b0; addr[0] = 10'd30; wdata[0] = 8'h42;
        repeat (S + 1) @(posedge clk);
        @(negedge clk);
        chk(drop[0] == 1'b0, "R8 held commit no drop", int'(drop[0]), 0);
        wdata[0] = 8'h43;
        repeat (3) @(negedge clk);
        chk(drop[0] == 1'b0, "R8 held no drop", int'(drop[0]), 0);
        cs_n[0] = 1'b1; we_n[0] = 1'b1;
        ref_mem[30] = 8'h42;
        rd(1, 10'd30, "R8 single write");

        // R3 deselected port ignores write and read strobes
        @(negedge clk);
        cs_n[0] = 1'b1; we_n[0] = 1'b0; oe_n[0] = 1'b0; addr[0] = 10'd3; wdata[0] = 8'hFF;
        repeat (S + 3) begin
            @(negedge clk);
            chk(drop[0] == 0 && rvalid[0] == 0, "R3 deselected quiet",
                int'({drop[0], rvalid[0]}), 0);
        end
        we_n[0] = 1'b1;
        @(negedge clk);
        chk(rvalid[0] == 0, "R3 deselected read", int'(rvalid[0]), 0);
        rd(0, 10'd3, "R3 memory unchanged");

        // R12 output enable high gives no data
        @(negedge clk);
        cs_n[1] = 1'b0; we_n[1] = 1'b1; oe_n[1] = 1'b1; addr[1] = 10'd3;
        @(posedge clk);
        @(negedge clk);
        chk(rvalid[1] == 0 && rdata[1] == 0, "R12 oe high", int'(rdata[1]), 0);
        cs_n[1] = 1'b1;

        repeat (3) @(negedge clk);
        chk(q0.size() == 0 && q1.size() == 0, "R2 all reads returned",
            q0.size() + q1.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule